// File: doc/BRIEF.md
# Sliced-Access General Register File

This block holds eight 32-bit general-purpose registers behind one write port and two read ports. Each port carries a register index and a two-bit access-size selector. A port can reach the low byte, the second byte (bits 15:8), the low half-word or the whole word. Narrow writes change only the addressed slice and keep the rest of the register. Narrow reads come out zero-extended to 32 bits.

Byte-granular access is allowed only on registers 0 to 3. Registers 4 to 7 offer only a half-word view and a full-word view. A byte access to one of those registers is refused and flagged. Read data and both error flags are registered, so every result appears one clock after the request. A read that targets the register being written in the same cycle returns the value from before the write.

Top module: `gpr_slice_file`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every register holds zero, both read data outputs are zero and all three error outputs are low.
- R2: A write with size code 2'b11 replaces all 32 bits of the addressed register with `wr_data`, and a read with size code 2'b11 presents the whole register on the read data output one clock after the request.
- R3: A write with size code 2'b10 loads `wr_data[15:0]` into bits 15:0 and leaves bits 31:16 unchanged.
- R4: A write with size code 2'b00 loads `wr_data[7:0]` into bits 7:0 and leaves bits 31:8 unchanged. It is legal only for registers 0 to 3.
- R5: A write with size code 2'b01 loads `wr_data[7:0]` into bits 15:8 and leaves bits 31:16 and 7:0 unchanged. It is legal only for registers 0 to 3.
- R6: Narrow reads are zero-extended. Size code 2'b00 gives bits 7:0, 2'b01 gives bits 15:8 in output bits 7:0, and 2'b10 gives bits 15:0. All higher output bits are zero.
- R7: A byte-size access (code 2'b00 or 2'b01) to registers 4 to 7 is illegal. Such a write changes no register and raises `wr_err` for one cycle, one clock later. Such a read raises that port's error output one clock later and returns zero data.
- R8: A read of the register being written in the same cycle returns the value held before that write. The new value is visible from the following request on.
- R9: The two read ports act independently, each with its own index, size, data and error.
- R10: With `wr_en` low, no register changes and `wr_err` stays low, whatever is on the other write inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register written |
| wr_size | input | 2 | Write slice: 00 low byte, 01 byte 1, 10 half, 11 word |
| wr_data | input | 32 | Write data, right-aligned |
| wr_err | output | 1 | Previous cycle's write was illegal and was dropped |
| ra_idx | input | 3 | Read port A register index |
| ra_size | input | 2 | Read port A slice code |
| ra_data | output | 32 | Read port A data, zero-extended, one cycle later |
| ra_err | output | 1 | Read port A request was illegal |
| rb_idx | input | 3 | Read port B register index |
| rb_size | input | 2 | Read port B slice code |
| rb_data | output | 32 | Read port B data, zero-extended, one cycle later |
| rb_err | output | 1 | Read port B request was illegal |

## Verification
Four properties are checked on every cycle. A register not targeted by a legal write keeps its value. A write error only follows a byte-size write request. A byte-size read leaves output bits above 7 at zero. A flagged read carries zero data. The bench scenarios are needed to show that the correct slice lands in the correct bit positions and that the neighbouring bits survive. They also show the old-value return on a same-cycle read and write, that the two read ports are independent, and that an illegal write leaves the target intact when it is later read back.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

  typedef enum logic [1:0] {
    ACC_LO8 = 2'b00,
    ACC_HI8 = 2'b01,
    ACC_W16 = 2'b10,
    ACC_W32 = 2'b11
  } acc_size_e;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

endpackage

// File: rtl/gprf_size_check.sv
module gprf_size_check #(
  parameter int IDX_W     = 3,
  parameter int BYTE_REGS = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  output logic             illegal
);
  import gprf_pkg::*;

  logic is_byte;

  always_comb begin
    is_byte = (acc_size_e'(size) == ACC_LO8) || (acc_size_e'(size) == ACC_HI8);
    illegal = is_byte && (int'(idx) >= BYTE_REGS);
  end

endmodule

// File: rtl/gprf_write_merge.sv
module gprf_write_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] new_word
);
  import gprf_pkg::*;

  always_comb begin
    new_word = old_word;
    case (acc_size_e'(size))
      ACC_LO8: new_word[BYTE_W-1:0]      = din[BYTE_W-1:0];
      ACC_HI8: new_word[HALF_W-1:BYTE_W] = din[BYTE_W-1:0];
      ACC_W16: new_word[HALF_W-1:0]      = din[HALF_W-1:0];
      default: new_word                  = din;
    endcase
  end

endmodule

// File: rtl/gprf_read_extract.sv
module gprf_read_extract #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] dout
);
  import gprf_pkg::*;

  always_comb begin
    dout = '0;
    case (acc_size_e'(size))
      ACC_LO8: dout[BYTE_W-1:0] = word[BYTE_W-1:0];
      ACC_HI8: dout[BYTE_W-1:0] = word[HALF_W-1:BYTE_W];
      ACC_W16: dout[HALF_W-1:0] = word[HALF_W-1:0];
      default: dout             = word;
    endcase
  end

endmodule

// File: rtl/gpr_slice_file.sv
module gpr_slice_file #(
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  parameter int BYTE_REGS = 4,
  parameter int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [1:0]        ra_size,
  output logic [DATA_W-1:0] ra_data,
  output logic              ra_err,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [1:0]        rb_size,
  output logic [DATA_W-1:0] rb_data,
  output logic              rb_err
);
  import gprf_pkg::*;

  localparam int RD_PORTS = 2;

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              wr_bad;
  logic              wr_ok;
  logic [DATA_W-1:0] wr_word;
  logic              wr_err_q;

  // write path
  gprf_size_check #(.IDX_W(IDX_W), .BYTE_REGS(BYTE_REGS)) u_wchk (
    .idx     (wr_idx),
    .size    (wr_size),
    .illegal (wr_bad)
  );

  gprf_write_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word (regs_q[wr_idx]),
    .din      (wr_data),
    .size     (wr_size),
    .new_word (wr_word)
  );

  assign wr_ok = wr_en && !wr_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
      wr_err_q <= 1'b0;
    end else begin
      if (wr_ok) regs_q[wr_idx] <= wr_word;
      wr_err_q <= wr_en && wr_bad;
    end
  end

  assign wr_err = wr_err_q;

  // R7
  wr_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> ($past(wr_en) && !$past(wr_size[1])));

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_hold
      // R10
      reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok && (wr_idx == IDX_W'(g))) |=> $stable(regs_q[g]));
    end
  endgenerate

  // read paths
  logic [IDX_W-1:0]  rp_idx  [RD_PORTS];
  logic [1:0]        rp_size [RD_PORTS];
  logic [DATA_W-1:0] rp_data [RD_PORTS];
  logic              rp_err  [RD_PORTS];

  assign rp_idx[0]  = ra_idx;
  assign rp_size[0] = ra_size;
  assign rp_idx[1]  = rb_idx;
  assign rp_size[1] = rb_size;

  genvar p;
  generate
    for (p = 0; p < RD_PORTS; p++) begin : g_rd
      logic              bad;
      logic [DATA_W-1:0] ext;
      logic [DATA_W-1:0] dq;
      logic              eq;

      gprf_size_check #(.IDX_W(IDX_W), .BYTE_REGS(BYTE_REGS)) u_rchk (
        .idx     (rp_idx[p]),
        .size    (rp_size[p]),
        .illegal (bad)
      );

      gprf_read_extract #(.DATA_W(DATA_W)) u_ext (
        .word (regs_q[rp_idx[p]]),
        .size (rp_size[p]),
        .dout (ext)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          dq <= '0;
          eq <= 1'b0;
        end else begin
          dq <= bad ? '0 : ext;
          eq <= bad;
        end
      end

      assign rp_data[p] = dq;
      assign rp_err[p]  = eq;

      // R6
      byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rp_size[p][1]) |-> (dq[DATA_W-1:BYTE_W] == '0));

      // R7
      err_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        eq |-> (dq == '0));
    end
  endgenerate

  assign ra_data = rp_data[0];
  assign ra_err  = rp_err[0];
  assign rb_data = rp_data[1];
  assign rb_err  = rp_err[1];

endmodule

// File: tb/gpr_slice_file_bench.sv
module gpr_slice_file_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err;
  logic [2:0]  ra_idx = '0;
  logic [1:0]  ra_size = 2'b11;
  logic [31:0] ra_data;
  logic        ra_err;
  logic [2:0]  rb_idx = '0;
  logic [1:0]  rb_size = 2'b11;
  logic [31:0] rb_data;
  logic        rb_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] a_data;
    logic        a_err;
    logic [31:0] b_data;
    logic        b_err;
    logic        w_err;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mdl [8];

  always #5 clk = ~clk;

  gpr_slice_file u_gpr_slice_file (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
    .ra_idx(ra_idx), .ra_size(ra_size), .ra_data(ra_data), .ra_err(ra_err),
    .rb_idx(rb_idx), .rb_size(rb_size), .rb_data(rb_data), .rb_err(rb_err)
  );

  function automatic bit illegal(input logic [2:0] idx, input logic [1:0] sz);
    return (sz[1] == 1'b0) && (idx >= 3'd4);
  endfunction

  function automatic logic [31:0] view(input logic [31:0] w, input logic [1:0] sz);
    case (sz)
      2'b00:   return {24'h0, w[7:0]};
      2'b01:   return {24'h0, w[15:8]};
      2'b10:   return {16'h0, w[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [2:0] wi, input logic [1:0] ws, input logic [31:0] wd,
                      input logic [2:0] ai, input logic [1:0] as, input logic [2:0] bi, input logic [1:0] bs,
                      input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
    ra_idx = ai; ra_size = as; rb_idx = bi; rb_size = bs;
    e.a_err  = illegal(ai, as);
    e.a_data = e.a_err ? 32'h0 : view(mdl[ai], as);
    e.b_err  = illegal(bi, bs);
    e.b_data = e.b_err ? 32'h0 : view(mdl[bi], bs);
    e.w_err  = we && illegal(wi, ws);
    e.tag    = tag;
    sb_q.push_back(e);
    if (we && !illegal(wi, ws)) begin
      case (ws)
        2'b00:   mdl[wi][7:0]  = wd[7:0];
        2'b01:   mdl[wi][15:8] = wd[7:0];
        2'b10:   mdl[wi][15:0] = wd[15:0];
        default: mdl[wi]       = wd;
      endcase
    end
  endtask

  // monitor: results appear after the edge that follows the request
  always @(posedge clk) begin
    #2;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, "ra_data", ra_data, e.a_data);
      check(e.tag, "ra_err", {31'h0, ra_err}, {31'h0, e.a_err});
      check(e.tag, "rb_data", rb_data, e.b_data);
      check(e.tag, "rb_err", {31'h0, rb_err}, {31'h0, e.b_err});
      check(e.tag, "wr_err", {31'h0, wr_err}, {31'h0, e.w_err});
    end
  end

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "ra_data", ra_data, 32'h0);
    check("R1", "wr_err", {31'h0, wr_err}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    // R1: all registers zero after reset
    for (int i = 0; i < 8; i += 2)
      step(1'b0, 3'd0, 2'b11, 32'h0, 3'(i), 2'b11, 3'(i + 1), 2'b11, "R1");

    // R2: full-word writes to every register, read back on both ports
    for (int i = 0; i < 8; i++)
      step(1'b1, 3'(i), 2'b11, 32'h1000_0000 * (i + 1) + 32'h0012_3456 + i,
           3'd0, 2'b11, 3'd0, 2'b11, "R2");
    for (int i = 0; i < 8; i++)
      step(1'b0, 3'd0, 2'b11, 32'h0, 3'(i), 2'b11, 3'(7 - i), 2'b11, "R2");

    // R3: half-word writes keep the upper half
    step(1'b1, 3'd1, 2'b10, 32'hAAAA_5555, 3'd1, 2'b11, 3'd6, 2'b11, "R3");
    step(1'b1, 3'd6, 2'b10, 32'hFFFF_BEEF, 3'd1, 2'b11, 3'd6, 2'b11, "R3");
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd1, 2'b11, 3'd6, 2'b11, "R3");

    // R4: low-byte write
    step(1'b1, 3'd2, 2'b00, 32'hFFFF_FF9A, 3'd2, 2'b11, 3'd2, 2'b00, "R4");
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd2, 2'b11, 3'd2, 2'b00, "R4");

    // R5: second-byte write from wr_data[7:0]
    step(1'b1, 3'd3, 2'b01, 32'h1234_56C3, 3'd3, 2'b11, 3'd3, 2'b01, "R5");
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd3, 2'b11, 3'd3, 2'b01, "R5");

    // R6: zero-extended narrow reads of a dense pattern
    step(1'b1, 3'd0, 2'b11, 32'hF1E2_D3C4, 3'd0, 2'b11, 3'd0, 2'b11, "R6");
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd0, 2'b00, 3'd0, 2'b01, "R6");
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd0, 2'b10, 3'd5, 2'b10, "R6");

    // R7: illegal byte write to reg 5 and reg 7, illegal byte reads
    step(1'b1, 3'd5, 2'b00, 32'h0000_00EE, 3'd5, 2'b00, 3'd7, 2'b01, "R7");
    step(1'b1, 3'd7, 2'b01, 32'h0000_0077, 3'd5, 2'b11, 3'd4, 2'b00, "R7");
    step(1'b1, 3'd4, 2'b10, 32'h0000_4444, 3'd7, 2'b11, 3'd4, 2'b11, "R7");
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd4, 2'b11, 3'd5, 2'b10, "R7");

    // R8: same-cycle read returns the old value, next sees the new one
    step(1'b1, 3'd0, 2'b11, 32'hCAFE_0001, 3'd0, 2'b11, 3'd0, 2'b10, "R8");
    step(1'b1, 3'd0, 2'b00, 32'h0000_0055, 3'd0, 2'b11, 3'd0, 2'b00, "R8");
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd0, 2'b11, 3'd0, 2'b00, "R8");

    // R9: ports read different registers and sizes at once
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd1, 2'b01, 3'd6, 2'b10, "R9");
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd7, 2'b00, 3'd3, 2'b00, "R9");

    // R10: write inputs active with wr_en low
    step(1'b0, 3'd2, 2'b11, 32'hDEAD_DEAD, 3'd2, 2'b11, 3'd2, 2'b11, "R10");
    step(1'b0, 3'd5, 2'b00, 32'hDEAD_DEAD, 3'd2, 2'b11, 3'd5, 2'b11, "R10");
    step(1'b0, 3'd0, 2'b11, 32'h0, 3'd2, 2'b11, 3'd5, 2'b11, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule